// File: doc/BRIEF.md
# Programmable External Memory Bus Controller

This block turns single internal bus requests into strobe-level read and write cycles on an external asynchronous memory bus. The requester raises `req` with an address, a direction, byte enables and write data, and holds them until `ack` comes back. The top address bits pick one of several memory regions. Each region has its own small control word, which holds an enable bit and a bus width of 8 or 16 bits. Each region also has a protocol word that sets the cycle timing: address latch enable stretch, strobe lengths, idle turnaround clocks around the strobe, and an extra address hold clock.

An access runs through a fixed sequence. First comes the latch phase of 1 plus the stretch count in clocks. Then an optional turnaround clock, then the strobe. After the strobe come an optional turnaround clock and an optional hold clock, and the acknowledge follows. The block never starts a bus cycle if the global enable is off or the selected region is disabled. In that case the request is answered in one clock with an error flag. A byte-gate option serves two 8-bit devices that share one region: it routes the write strobe onto address bit 0 instead of using the byte lane enables.

The data bus is brought out as a pad-side triple: an output value, an output enable and an input value. The region's protocol word is sampled when a request is accepted, so a register write during an access does not change that access.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset the global enable word reads 0x0000, every region control word reads 0x0000, every protocol word reads 0x70FF, and all bus outputs (`ext_ale`, `ext_rd`, `ext_wr`, `ext_d_oe`, `ack`, `ext_addr`) are 0.
- R2: Register index 0 is the global enable (bit 0). Index 1+k is the control word of region k: bit 0 enables the region and bit 1 selects a 16-bit bus. Index 1+REGIONS+k is the protocol word of region k. Unimplemented bits read 0, and protocol bit 11 always reads 0.
- R3: A request made while the global enable is 0, or to a disabled region, raises `ack` and `err` together on the clock after acceptance. It asserts no latch enable, strobe or data drive.
- R4: The region is taken from the top log2(REGIONS) bits of `req_addr`, and that region's protocol word governs the access.
- R5: `ext_ale` is high for 1 + prot[14:12] clocks, starting on the clock after acceptance.
- R6: On a read, `ext_rd` is high for prot[3:0]+1 clocks. `rdata` takes `ext_d_i` as sampled at the end of the last strobe clock, zero-extended from bits [7:0] on an 8-bit region.
- R7: On a write, `ext_wr` is high for prot[7:4]+1 clocks, and `ext_rd` stays low.
- R8: When prot[8] is 0 (for writes) or prot[9] is 0 (for reads), one idle clock is inserted before the strobe and one after it. When the bit is 1, neither is inserted.
- R9: When prot[10] is 0, the address stays driven for one extra clock after the strobe phase. When it is 1, there is no extra clock.
- R10: `ack` is a one-clock pulse on the clock after the last bus phase. `ext_rd` and `ext_wr` are never high together.
- R11: On a write, `ext_d_oe` is high from the first latch clock through the hold clock. The driven value is the write data, or only its low byte on an 8-bit region. `ext_d_oe` is never high during a read.
- R12: With byte-gate off, on a 16-bit region `ext_bhe`/`ext_ble` follow `req_be[1]`/`req_be[0]` for the whole access. On an 8-bit region only `ext_ble` is asserted.
- R13: With prot[15] set, `ext_bhe` and `ext_ble` stay low. On a write, `ext_addr[0]` is high only while `ext_wr` is high and the request address bit 0 is 1. On a read, `ext_addr[0]` follows the request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | CA_W (4) | Register index |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational) |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_be | input | 2 | Byte enables |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | Access complete pulse |
| err | output | 1 | Access refused (with ack) |
| rdata | output | 16 | Last read data |
| ext_addr | output | ADDR_W | External address bus |
| ext_ale | output | 1 | Address latch enable |
| ext_rd | output | 1 | Read strobe (active high) |
| ext_wr | output | 1 | Write strobe (active high) |
| ext_bhe | output | 1 | High byte enable |
| ext_ble | output | 1 | Low byte enable |
| ext_d_o | output | 16 | Data bus output value |
| ext_d_oe | output | 1 | Data bus output enable |
| ext_d_i | input | 16 | Data bus input value |

## Verification
The hardest case to reach from the ports is showing that read data is captured on the last strobe clock and not on an earlier or later one. The bench changes `ext_d_i` on every strobe clock to a base value plus the number of strobe clocks seen so far. The captured value therefore shows exactly which clock was sampled. A sweep over every strobe length, every stretch count and every turnaround/hold combination covers both widths and both directions. For each access, the bench predicts arithmetically the count of latch clocks, the start and length of the strobe, the address and drive windows, and the acknowledge clock.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

   localparam int DATA_W = 16;
   localparam int PROT_W = 16;

   // protocol word bit positions
   localparam int P_RD_LSB   = 0;
   localparam int P_WR_LSB   = 4;
   localparam int P_NO_WRT   = 8;
   localparam int P_NO_RDT   = 9;
   localparam int P_NO_HOLD  = 10;
   localparam int P_RSVD     = 11;
   localparam int P_WS_LSB   = 12;
   localparam int P_GATE     = 15;

   localparam logic [PROT_W-1:0] PROT_RESET = 16'h70FF;
   localparam logic [PROT_W-1:0] PROT_WMASK = ~(16'(1) << P_RSVD);

   typedef enum logic [2:0] {
      S_IDLE,
      S_ALE,
      S_PRE,
      S_STB,
      S_POST,
      S_HOLD,
      S_DONE
   } xb_state_e;

endpackage

// File: rtl/xbus_regs.sv
module xbus_regs
   import xbus_pkg::*;
#(
   parameter int REGIONS = 4,
   parameter int CA_W    = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             cfg_we,
   input  logic [CA_W-1:0]                  cfg_idx,
   input  logic [DATA_W-1:0]                cfg_wdata,
   output logic [DATA_W-1:0]                cfg_rdata,
   output logic                             glb_en,
   output logic [REGIONS-1:0][1:0]          ctrl_q,
   output logic [REGIONS-1:0][PROT_W-1:0]   prot_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glb_en <= 1'b0;
      end else if (cfg_we && cfg_idx == '0) begin
         glb_en <= cfg_wdata[0];
      end
   end

   for (genvar g = 0; g < REGIONS; g++) begin : g_region
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctrl_q[g] <= 2'b00;
            prot_q[g] <= PROT_RESET;
         end else if (cfg_we) begin
            if (cfg_idx == CA_W'(1 + g))
               ctrl_q[g] <= cfg_wdata[1:0];
            if (cfg_idx == CA_W'(1 + REGIONS + g))
               prot_q[g] <= cfg_wdata & PROT_WMASK;
         end
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (cfg_idx == '0)
         cfg_rdata = {{(DATA_W-1){1'b0}}, glb_en};
      for (int i = 0; i < REGIONS; i++) begin
         if (cfg_idx == CA_W'(1 + i))
            cfg_rdata = {{(DATA_W-2){1'b0}}, ctrl_q[i]};
         if (cfg_idx == CA_W'(1 + REGIONS + i))
            cfg_rdata = prot_q[i];
      end
   end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int REGIONS = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             req,
   input  logic                             req_we,
   input  logic [ADDR_W-1:0]                req_addr,
   input  logic [1:0]                       req_be,
   input  logic [DATA_W-1:0]                req_wdata,
   input  logic                             glb_en,
   input  logic [REGIONS-1:0][1:0]          ctrl_q,
   input  logic [REGIONS-1:0][PROT_W-1:0]   prot_q,
   input  logic [DATA_W-1:0]                ext_d_i,
   output xb_state_e                        st_q,
   output logic                             we_q,
   output logic                             wide_q,
   output logic                             gate_q,
   output logic [1:0]                       be_q,
   output logic [ADDR_W-1:0]                addr_q,
   output logic [DATA_W-1:0]                wdata_q,
   output logic                             ack,
   output logic                             err,
   output logic [DATA_W-1:0]                rdata
);

   localparam int RSEL_W = $clog2(REGIONS);

   logic [RSEL_W-1:0]  rsel;
   logic [PROT_W-1:0]  psel;
   logic               prot_unused;
   logic [3:0]         cnt_q;
   logic [3:0]         len_q;
   logic               turn_q;
   logic               hold_q;
   logic               err_q;
   logic               ok;

   assign rsel        = req_addr[ADDR_W-1 -: RSEL_W];
   assign psel        = prot_q[rsel];
   assign prot_unused = psel[P_RSVD];
   assign ok          = glb_en && ctrl_q[rsel][0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         cnt_q   <= '0;
         len_q   <= '0;
         turn_q  <= 1'b0;
         hold_q  <= 1'b0;
         err_q   <= 1'b0;
         we_q    <= 1'b0;
         wide_q  <= 1'b0;
         gate_q  <= 1'b0;
         be_q    <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata   <= '0;
      end else begin
         case (st_q)
            S_IDLE: if (req) begin
               we_q    <= req_we;
               be_q    <= req_be;
               addr_q  <= req_addr;
               wdata_q <= req_wdata;
               wide_q  <= ctrl_q[rsel][1];
               gate_q  <= psel[P_GATE];
               hold_q  <= !psel[P_NO_HOLD];
               turn_q  <= req_we ? !psel[P_NO_WRT] : !psel[P_NO_RDT];
               len_q   <= req_we ? psel[P_WR_LSB +: 4] : psel[P_RD_LSB +: 4];
               cnt_q   <= {1'b0, psel[P_WS_LSB +: 3]};
               err_q   <= !ok;
               st_q    <= ok ? S_ALE : S_DONE;
            end
            S_ALE: begin
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - 4'd1;
               end else if (turn_q) begin
                  st_q <= S_PRE;
               end else begin
                  st_q  <= S_STB;
                  cnt_q <= len_q;
               end
            end
            S_PRE: begin
               st_q  <= S_STB;
               cnt_q <= len_q;
            end
            S_STB: begin
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - 4'd1;
               end else begin
                  if (!we_q)
                     rdata <= wide_q ? ext_d_i : {8'h00, ext_d_i[7:0]};
                  st_q <= turn_q ? S_POST : (hold_q ? S_HOLD : S_DONE);
               end
            end
            S_POST:  st_q <= hold_q ? S_HOLD : S_DONE;
            S_HOLD:  st_q <= S_DONE;
            S_DONE: begin
               st_q  <= S_IDLE;
               err_q <= 1'b0;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign ack = (st_q == S_DONE);
   assign err = (st_q == S_DONE) && err_q;

endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
   import xbus_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter bit GATE_EN = 1'b1
) (
   input  xb_state_e           st_q,
   input  logic                we_q,
   input  logic                wide_q,
   input  logic                gate_q,
   input  logic [1:0]          be_q,
   input  logic [ADDR_W-1:0]   addr_q,
   input  logic [DATA_W-1:0]   wdata_q,
   output logic [ADDR_W-1:0]   ext_addr,
   output logic                ext_ale,
   output logic                ext_rd,
   output logic                ext_wr,
   output logic                ext_bhe,
   output logic                ext_ble,
   output logic [DATA_W-1:0]   ext_d_o,
   output logic                ext_d_oe
);

   logic active;
   logic gate;
   logic [ADDR_W-1:0] addr_base;

   assign active = (st_q == S_ALE) || (st_q == S_PRE) || (st_q == S_STB) ||
                   (st_q == S_POST) || (st_q == S_HOLD);
   assign ext_ale  = (st_q == S_ALE);
   assign ext_rd   = (st_q == S_STB) && !we_q;
   assign ext_wr   = (st_q == S_STB) && we_q;
   assign ext_d_oe = active && we_q;
   assign ext_d_o  = ext_d_oe ? (wide_q ? wdata_q : {8'h00, wdata_q[7:0]}) : '0;
   assign addr_base = active ? addr_q : '0;

   if (GATE_EN) begin : g_gate
      assign gate = gate_q;
   end else begin : g_nogate
      logic gate_unused;
      assign gate_unused = gate_q;
      assign gate = 1'b0;
   end

   always_comb begin
      ext_addr = addr_base;
      if (gate && we_q)
         ext_addr[0] = addr_base[0] && ext_wr;
   end

   always_comb begin
      ext_bhe = 1'b0;
      ext_ble = 1'b0;
      if (active && !gate) begin
         ext_bhe = wide_q ? be_q[1] : 1'b0;
         ext_ble = wide_q ? be_q[0] : 1'b1;
      end
   end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
   import xbus_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int REGIONS = 4,
   parameter bit GATE_EN = 1'b1,
   localparam int CA_W   = $clog2(2 * REGIONS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [CA_W-1:0]     cfg_idx,
   input  logic [15:0]         cfg_wdata,
   output logic [15:0]         cfg_rdata,
   input  logic                req,
   input  logic                req_we,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [1:0]          req_be,
   input  logic [15:0]         req_wdata,
   output logic                ack,
   output logic                err,
   output logic [15:0]         rdata,
   output logic [ADDR_W-1:0]   ext_addr,
   output logic                ext_ale,
   output logic                ext_rd,
   output logic                ext_wr,
   output logic                ext_bhe,
   output logic                ext_ble,
   output logic [15:0]         ext_d_o,
   output logic                ext_d_oe,
   input  logic [15:0]         ext_d_i
);

   if (REGIONS < 2 || (REGIONS & (REGIONS - 1)) != 0) begin : g_bad_regions
      $error("REGIONS must be a power of two of at least 2");
   end
   if (ADDR_W < $clog2(REGIONS) + 2) begin : g_bad_addr
      $error("ADDR_W too small for region select plus byte bit");
   end

   logic                            glb_en;
   logic [REGIONS-1:0][1:0]         ctrl_q;
   logic [REGIONS-1:0][PROT_W-1:0]  prot_q;
   xb_state_e                       st_q;
   logic                            we_q, wide_q, gate_q;
   logic [1:0]                      be_q;
   logic [ADDR_W-1:0]               addr_q;
   logic [DATA_W-1:0]               wdata_q;

   xbus_regs #(.REGIONS(REGIONS), .CA_W(CA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_idx   (cfg_idx),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .glb_en    (glb_en),
      .ctrl_q    (ctrl_q),
      .prot_q    (prot_q)
   );

   xbus_seq #(.ADDR_W(ADDR_W), .REGIONS(REGIONS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .req_we    (req_we),
      .req_addr  (req_addr),
      .req_be    (req_be),
      .req_wdata (req_wdata),
      .glb_en    (glb_en),
      .ctrl_q    (ctrl_q),
      .prot_q    (prot_q),
      .ext_d_i   (ext_d_i),
      .st_q      (st_q),
      .we_q      (we_q),
      .wide_q    (wide_q),
      .gate_q    (gate_q),
      .be_q      (be_q),
      .addr_q    (addr_q),
      .wdata_q   (wdata_q),
      .ack       (ack),
      .err       (err),
      .rdata     (rdata)
   );

   xbus_pins #(.ADDR_W(ADDR_W), .GATE_EN(GATE_EN)) u_pins (
      .st_q      (st_q),
      .we_q      (we_q),
      .wide_q    (wide_q),
      .gate_q    (gate_q),
      .be_q      (be_q),
      .addr_q    (addr_q),
      .wdata_q   (wdata_q),
      .ext_addr  (ext_addr),
      .ext_ale   (ext_ale),
      .ext_rd    (ext_rd),
      .ext_wr    (ext_wr),
      .ext_bhe   (ext_bhe),
      .ext_ble   (ext_ble),
      .ext_d_o   (ext_d_o),
      .ext_d_oe  (ext_d_oe)
   );

endmodule

// File: rtl/xbus_chk.sv
module xbus_chk (
   input logic clk,
   input logic rst_n,
   input logic ack,
   input logic err,
   input logic ext_ale,
   input logic ext_rd,
   input logic ext_wr,
   input logic ext_d_oe
);

   // R10
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ext_rd && ext_wr));

   // R10
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   // R3
   err_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> ack);

   // R3
   err_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !$past(ext_ale) && !$past(ext_d_oe) && !$past(ext_rd) && !$past(ext_wr));

   // R11
   read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rd |-> !ext_d_oe);

   // R11
   write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_wr |-> ext_d_oe);

   // R5
   ale_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_ale |-> !ext_rd && !ext_wr);

endmodule

bind xbus_ctrl xbus_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ack      (ack),
   .err      (err),
   .ext_ale  (ext_ale),
   .ext_rd   (ext_rd),
   .ext_wr   (ext_wr),
   .ext_d_oe (ext_d_oe)
);

// File: tb/xbus_ctrl_test.sv
`timescale 1ns/1ps
module xbus_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_idx = '0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        req = 1'b0, req_we = 1'b0;
   logic [15:0] req_addr = '0;
   logic [1:0]  req_be = '0;
   logic [15:0] req_wdata = '0;
   logic        ack, err;
   logic [15:0] rdata;
   logic [15:0] ext_addr;
   logic        ext_ale, ext_rd, ext_wr, ext_bhe, ext_ble, ext_d_oe;
   logic [15:0] ext_d_o;
   logic [15:0] ext_d_i = '0;

   int tests = 0;
   int fails = 0;

   int cyc, n_ale, n_stb, n_wrong, first_stb, n_oe, n_addr, n_a0, n_bhe, n_ble, n_dbad;
   logic got_err;
   logic wide_of [4] = '{1'b1, 1'b0, 1'b1, 1'b1};

   always #5 clk = ~clk;

   xbus_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req(req), .req_we(req_we),
      .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata), .ack(ack),
      .err(err), .rdata(rdata), .ext_addr(ext_addr), .ext_ale(ext_ale),
      .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_bhe(ext_bhe), .ext_ble(ext_ble),
      .ext_d_o(ext_d_o), .ext_d_oe(ext_d_oe), .ext_d_i(ext_d_i)
   );

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
      end
   endtask

   task automatic wreg(input int idx, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rreg(input int idx, output logic [15:0] d);
      @(negedge clk);
      cfg_idx = 4'(idx);
      #1 d = cfg_rdata;
   endtask

   task automatic access(input logic we, input logic [15:0] addr, input logic [1:0] be,
                         input logic [15:0] wd, input logic [15:0] exp_do,
                         input logic [15:0] dbase);
      @(negedge clk);
      req = 1'b1; req_we = we; req_addr = addr; req_be = be; req_wdata = wd;
      ext_d_i = dbase;
      cyc = 0; n_ale = 0; n_stb = 0; n_wrong = 0; first_stb = 0; n_oe = 0;
      n_addr = 0; n_a0 = 0; n_bhe = 0; n_ble = 0; n_dbad = 0; got_err = 1'b0;
      while (1) begin
         @(posedge clk);
         @(negedge clk);
         cyc++;
         if (ack) begin
            got_err = err;
            break;
         end
         if (cyc > 200) break;
         if (ext_ale) n_ale++;
         if ((we && ext_wr) || (!we && ext_rd)) begin
            n_stb++;
            if (first_stb == 0) first_stb = cyc;
         end
         if ((we && ext_rd) || (!we && ext_wr)) n_wrong++;
         if (ext_d_oe) begin
            n_oe++;
            if (ext_d_o != exp_do) n_dbad++;
         end
         if (ext_addr[15:1] == addr[15:1]) n_addr++;
         if (ext_addr[0]) n_a0++;
         if (ext_bhe) n_bhe++;
         if (ext_ble) n_ble++;
         ext_d_i = dbase + 16'(n_stb);
      end
      req = 1'b0;
   endtask

   task automatic run_case(input logic we, input int region, input logic [15:0] prot,
                           input logic [1:0] be, input logic a0);
      int ws, len, tt, hd, total;
      logic gate, wide;
      logic [15:0] addr, wd, exp_do, dbase, exp_rd;
      wreg(5 + region, prot);
      ws    = int'(prot[14:12]);
      len   = we ? int'(prot[7:4]) : int'(prot[3:0]);
      tt    = we ? int'(!prot[8]) : int'(!prot[9]);
      hd    = int'(!prot[10]);
      gate  = prot[15];
      wide  = wide_of[region];
      total = 1 + ws + tt + len + 1 + tt + hd;
      addr  = {2'(region), 13'h052D, a0};
      wd    = 16'hB4C3 ^ prot;
      exp_do = wide ? wd : {8'h00, wd[7:0]};
      dbase = 16'hA710 + 16'(region * 32);
      access(we, addr, be, wd, exp_do, dbase);
      chk("R10 ack clock", cyc, total + 1);
      chk("R3 no error on enabled region", int'(got_err), 0);
      chk("R5 ale length", n_ale, 1 + ws);
      chk(we ? "R7 write strobe length" : "R6 read strobe length", n_stb, len + 1);
      chk("R10 opposite strobe idle", n_wrong, 0);
      chk("R8 strobe start clock", first_stb, 2 + ws + tt);
      chk("R9 address window", n_addr, total);
      chk("R11 drive window", n_oe, we ? total : 0);
      chk("R11 drive value", n_dbad, 0);
      if (gate) begin
         chk("R13 bhe off in gate mode", n_bhe, 0);
         chk("R13 ble off in gate mode", n_ble, 0);
         chk("R13 addr bit0 gating", n_a0, a0 ? (we ? len + 1 : total) : 0);
      end else if (wide) begin
         chk("R12 bhe wide", n_bhe, be[1] ? total : 0);
         chk("R12 ble wide", n_ble, be[0] ? total : 0);
      end else begin
         chk("R12 bhe narrow", n_bhe, 0);
         chk("R12 ble narrow", n_ble, total);
      end
      if (!we) begin
         exp_rd = dbase + 16'(len + 1);
         if (!wide) exp_rd = {8'h00, exp_rd[7:0]};
         chk("R6 read data capture", int'(rdata), int'(exp_rd));
      end
   endtask

   task automatic err_case(input string tag, input int region);
      access(1'b1, {2'(region), 14'h1234}, 2'b11, 16'h5555, 16'h5555, 16'h0);
      chk({tag, " ack clock"}, cyc, 1);
      chk({tag, " err flag"}, int'(got_err), 1);
      chk({tag, " no ale"}, n_ale, 0);
      chk({tag, " no strobe"}, n_stb + n_wrong, 0);
      chk({tag, " no drive"}, n_oe, 0);
   endtask

   initial begin
      #1_500_000;
      $display("FAIL watchdog: actual timeout expected completion");
      fails++;
      tests++;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 ale idle", int'(ext_ale), 0);
      chk("R1 strobes idle", int'(ext_rd | ext_wr), 0);
      chk("R1 drive idle", int'(ext_d_oe), 0);
      chk("R1 ack idle", int'(ack), 0);
      chk("R1 addr idle", int'(ext_addr), 0);
      rreg(0, d); chk("R1 global reset", int'(d), 0);
      for (int k = 0; k < 4; k++) begin
         rreg(1 + k, d); chk("R1 control reset", int'(d), 0);
         rreg(5 + k, d); chk("R1 protocol reset", int'(d), 16'h70FF);
      end

      // R2 register map and unimplemented bits
      wreg(0, 16'hFFFF); rreg(0, d); chk("R2 global bits", int'(d), 1);
      wreg(2, 16'hFFFF); rreg(2, d); chk("R2 control bits", int'(d), 3);
      wreg(6, 16'hFFFF); rreg(6, d); chk("R2 protocol reserved bit", int'(d), 16'hF7FF);
      rreg(5, d); chk("R2 neighbour protocol untouched", int'(d), 16'h70FF);

      // R3 global enable off
      wreg(0, 16'h0000);
      wreg(1, 16'h0003);
      err_case("R3 global off", 0);

      wreg(0, 16'h0001);
      wreg(2, 16'h0001);
      wreg(3, 16'h0003);
      wreg(4, 16'h0000);
      err_case("R3 disabled region", 3);

      // sweep strobe lengths, stretch counts and flag patterns on both widths
      for (int n = 0; n < 16; n++) begin
         logic [15:0] p;
         p = 16'(((n * 3) % 8) << 12) | 16'(((n >> 1) & 7) << 8) |
             16'((15 - n) << 4) | 16'(n);
         run_case(1'b0, 0, p, 2'(n % 4), 1'b0);
         run_case(1'b1, 0, p, 2'((n + 1) % 4), 1'b1);
         run_case(1'b0, 1, p, 2'b11, 1'b0);
         run_case(1'b1, 1, p, 2'b01, 1'b0);
      end

      // R8 R9 every turnaround/hold combination
      for (int f = 0; f < 8; f++) begin
         run_case(1'b0, 0, 16'(2 << 12) | 16'(f << 8) | 16'h0031, 2'b11, 1'b0);
         run_case(1'b1, 0, 16'(2 << 12) | 16'(f << 8) | 16'h0031, 2'b10, 1'b0);
      end

      // R13 byte-gate mode
      run_case(1'b1, 2, 16'h9023, 2'b11, 1'b1);
      run_case(1'b1, 2, 16'h9023, 2'b11, 1'b0);
      run_case(1'b0, 2, 16'h9023, 2'b11, 1'b1);

      // R4 region select picks its own protocol word
      wreg(5, 16'h0702);
      wreg(6, 16'h0705);
      wreg(7, 16'h0709);
      for (int r = 0; r < 3; r++) begin
         access(1'b0, {2'(r), 14'h0100}, 2'b11, 16'h0, 16'h0, 16'h0);
         chk("R4 region strobe length", n_stb, (r == 0) ? 3 : ((r == 1) ? 6 : 10));
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule